// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog counter that runs on the system oscillator clock. Software chooses one of four power-of-two intervals. When the chosen interval runs out, the block sets an interrupt status flag. The flag can also drive an interrupt request, and that request can be masked. After the interval a second, fixed window begins. If software has not restarted the counter by the end of that window, the block produces a processor reset pulse of fixed length. It also records that the last reset came from the watchdog.

A restart strobe clears the count at any time. A run enable freezes the count while it is low. When the reset enable is low, the block still wraps its count at the end of the second window, so the block works as a periodic interrupt source that never resets the processor. The two status flags are sticky and each has its own clear strobe. If a set and a clear arrive in the same cycle, the set wins.

Top module: `wdog_twostage`

## Requirements
- R1: While rst_n is low and right after it is released, irq_req, wd_reset_pulse, irq_status and wdreset_status are all 0 and the count is zero.
- R2: interval_sel values 0, 1, 2 and 3 select a threshold of 2^(BASE_EXP + STEP_EXP*interval_sel) counted cycles (by default 2^16, 2^19, 2^22 and 2^25). irq_status becomes 1 in the cycle after the threshold-th counted clock edge that follows a restart.
- R3: irq_req is 1 exactly when irq_status is 1 and irq_enable is 1. irq_status is set whatever the value of irq_enable.
- R4: While restart is high, the next count is zero. A restart given before the threshold keeps both the interrupt and the reset from occurring.
- R5: If no restart arrives, a watchdog reset fires on counted edge threshold+POST_WIN (POST_WIN defaults to 512). wd_reset_pulse is then 1 for exactly PULSE_LEN cycles, and the count starts again from zero.
- R6: While reset_enable is 0, wd_reset_pulse stays 0 and wdreset_status is not set. The count still wraps to zero at threshold+POST_WIN, so the interrupt point comes round again.
- R7: While run_enable is 0 and restart is 0, the count holds its value.
- R8: irq_status stays 1 until a cycle with irq_status_clr high clears it. If the interrupt point and the clear fall in the same cycle, the flag is set.
- R9: wdreset_status is set when a watchdog reset fires and stays set, after the pulse ends, until a cycle with wdreset_status_clr high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_enable | input | 1 | Count enable |
| interval_sel | input | 2 | Interval choice, 0 to 3 |
| irq_enable | input | 1 | Lets irq_status drive irq_req |
| reset_enable | input | 1 | Lets the second window end in a reset pulse |
| restart | input | 1 | Software restart strobe, clears the count |
| irq_status_clr | input | 1 | Clears irq_status |
| wdreset_status_clr | input | 1 | Clears wdreset_status |
| irq_req | output | 1 | Interrupt request |
| wd_reset_pulse | output | 1 | Processor reset pulse |
| irq_status | output | 1 | Sticky interrupt-point flag |
| wdreset_status | output | 1 | Sticky watchdog-reset flag |

## Verification
The flags and the reset pulse come from registers. For a run of n counted edges after a restart, irq_status reads 1 when n is at least the threshold. wd_reset_pulse reads 1 when n is in the range threshold+POST_WIN to threshold+POST_WIN+PULSE_LEN-1. irq_req follows irq_status combinationally. The bench uses small interval parameters so that every selection can be exercised. It drives all inputs on falling edges and samples on the falling edge after the last counted rising edge. This places each check exactly on the boundary before a result is due, or on the first cycle it is due. Same-cycle set-and-clear and the wrap with the reset disabled are each checked on the edge where they take effect and on the edge before it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NUM_SEL = 4;
  localparam int SEL_W   = 2;

  // Width needed to hold the largest threshold plus the post window.
  function automatic int count_width(input int base_exp, input int step_exp, input int post_win);
    return $clog2((1 << (base_exp + step_exp * (NUM_SEL - 1))) + post_win + 1);
  endfunction
endpackage

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int STEP_EXP = 3,
  parameter int POST_WIN = 512,
  parameter int CNT_W    = count_width(BASE_EXP, STEP_EXP, POST_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_enable,
  input  logic             restart,
  input  logic [SEL_W-1:0] interval_sel,
  output logic             irq_hit,
  output logic             wrap_hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thr, irq_pt, wrap_pt;
  logic             tick;

  always_comb begin
    tick    = run_enable & ~restart;
    thr     = CNT_W'(1) << (BASE_EXP + STEP_EXP * int'(interval_sel));
    irq_pt  = thr - CNT_W'(1);
    wrap_pt = thr + CNT_W'(POST_WIN) - CNT_W'(1);
    irq_hit  = tick && (cnt_q == irq_pt);
    wrap_hit = tick && (cnt_q >= wrap_pt);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart)       cnt_d = '0;
    else if (wrap_hit) cnt_d = '0;
    else if (tick)     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) restart |=> cnt_q == '0); // R4
  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (!run_enable && !restart) |=> $stable(cnt_q)); // R7
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wrap_hit |=> cnt_q == '0); // R5
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_hit,
  input  logic fire,
  input  logic irq_status_clr,
  input  logic wdreset_status_clr,
  output logic irq_status,
  output logic wdreset_status
);
  logic irq_q, irq_d, wdr_q, wdr_d;

  // Set has priority over clear for both flags.
  always_comb begin
    irq_d = irq_q;
    if (irq_hit)             irq_d = 1'b1;
    else if (irq_status_clr) irq_d = 1'b0;
    wdr_d = wdr_q;
    if (fire)                    wdr_d = 1'b1;
    else if (wdreset_status_clr) wdr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      wdr_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      wdr_q <= wdr_d;
    end
  end

  assign irq_status     = irq_q;
  assign wdreset_status = wdr_q;

  AST_IRQ_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) irq_hit |=> irq_status); // R2
  AST_IRQ_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_status && !irq_status_clr) |=> irq_status); // R8
  AST_WDR_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (wdreset_status && !wdreset_status_clr) |=> wdreset_status); // R9
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 4,
  localparam int PW = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (fire)              left_d = PW'(PULSE_LEN);
    else if (left_q != '0) left_d = left_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse = (left_q != '0);

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n) fire |=> pulse); // R5
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdt_pkg::*;
#(
  parameter int BASE_EXP  = 16,
  parameter int STEP_EXP  = 3,
  parameter int POST_WIN  = 512,
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_enable,
  input  logic [1:0] interval_sel,
  input  logic       irq_enable,
  input  logic       reset_enable,
  input  logic       restart,
  input  logic       irq_status_clr,
  input  logic       wdreset_status_clr,
  output logic       irq_req,
  output logic       wd_reset_pulse,
  output logic       irq_status,
  output logic       wdreset_status
);
  logic irq_hit, wrap_hit, fire;

  wdt_count #(
    .BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .POST_WIN(POST_WIN)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .run_enable(run_enable), .restart(restart),
    .interval_sel(interval_sel), .irq_hit(irq_hit), .wrap_hit(wrap_hit)
  );

  assign fire = wrap_hit & reset_enable;

  wdt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .irq_hit(irq_hit), .fire(fire),
    .irq_status_clr(irq_status_clr), .wdreset_status_clr(wdreset_status_clr),
    .irq_status(irq_status), .wdreset_status(wdreset_status)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(wd_reset_pulse)
  );

  assign irq_req = irq_status & irq_enable;

  AST_NO_RESET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (!reset_enable && !wd_reset_pulse) |=> !wd_reset_pulse); // R6
  AST_RESET_MARKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $rose(wd_reset_pulse) |-> wdreset_status); // R9
endmodule

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;
  // Small intervals: thresholds 16, 32, 64, 128; post window 8; pulse 3.
  localparam int BASE = 4, STEP = 1, POST = 8, PLEN = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic run_enable, irq_enable, reset_enable, restart, iclr, rclr;
  logic [1:0] interval_sel;
  logic irq_req, wd_reset_pulse, irq_status, wdreset_status;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_twostage #(.BASE_EXP(BASE), .STEP_EXP(STEP), .POST_WIN(POST), .PULSE_LEN(PLEN)) u_wdog_twostage (
    .clk(clk), .rst_n(rst_n), .run_enable(run_enable), .interval_sel(interval_sel),
    .irq_enable(irq_enable), .reset_enable(reset_enable), .restart(restart),
    .irq_status_clr(iclr), .wdreset_status_clr(rclr),
    .irq_req(irq_req), .wd_reset_pulse(wd_reset_pulse),
    .irq_status(irq_status), .wdreset_status(wdreset_status)
  );

  typedef struct packed {
    logic [1:0] sel; logic ien; logic ren; logic [7:0] n;
    logic e_irq; logic e_rst; logic e_if; logic e_rf;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 1'b0, 8'd15,  1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 8'd16,  1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 8'd16,  1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd1, 1'b1, 1'b0, 8'd31,  1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 8'd32,  1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b1, 1'b0, 8'd63,  1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 8'd64,  1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd3, 1'b1, 1'b0, 8'd127, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 8'd128, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b1, 1'b1, 8'd23,  1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b1, 8'd24,  1'b0, 1'b1, 1'b1, 1'b1},
    '{2'd0, 1'b1, 1'b1, 8'd26,  1'b1, 1'b1, 1'b1, 1'b1},
    '{2'd0, 1'b1, 1'b1, 8'd27,  1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd1, 1'b1, 1'b0, 8'd40,  1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b1, 1'b1, 8'd72,  1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic ei, input logic er, input logic eif, input logic erf);
    check(tag, "irq_req", irq_req, ei);
    check(tag, "wd_reset_pulse", wd_reset_pulse, er);
    check(tag, "irq_status", irq_status, eif);
    check(tag, "wdreset_status", wdreset_status, erf);
  endtask

  // Idle, then restart with both flags cleared, then count n edges; sample at negedge.
  task automatic start_run(input logic [1:0] s, input logic ie, input logic re, input int n);
    run_enable = 1'b0;
    repeat (PLEN + 2) @(negedge clk);
    interval_sel = s; irq_enable = ie; reset_enable = re;
    restart = 1'b1; iclr = 1'b1; rclr = 1'b1;
    @(negedge clk);
    restart = 1'b0; iclr = 1'b0; rclr = 1'b0; run_enable = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_enable = 1'b0; interval_sel = 2'd0; irq_enable = 1'b1;
    reset_enable = 1'b1; restart = 1'b0; iclr = 1'b0; rclr = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    run_enable = 1'b1;
    repeat (15) @(negedge clk);
    check_all("R1 count from zero after release", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 count from zero after release", "irq_status", irq_status, 1'b1);

    for (int i = 0; i < NV; i++) begin
      start_run(VEC[i].sel, VEC[i].ien, VEC[i].ren, int'(VEC[i].n));
      check_all($sformatf("R2/R3/R5/R6 vector %0d", i), VEC[i].e_irq, VEC[i].e_rst, VEC[i].e_if, VEC[i].e_rf);
    end

    // R9: flag persists after pulse, clears on strobe
    run_enable = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 after pulse", "wdreset_status", wdreset_status, 1'b1);
    rclr = 1'b1; @(negedge clk); rclr = 1'b0;
    check("R9 cleared", "wdreset_status", wdreset_status, 1'b0);

    // R4: repeated restarts before threshold
    start_run(2'd0, 1'b1, 1'b1, 12);
    restart = 1'b1; @(negedge clk); restart = 1'b0;
    repeat (12) @(negedge clk);
    restart = 1'b1; @(negedge clk); restart = 1'b0;
    repeat (15) @(negedge clk);
    check_all("R4 restarts hold off", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R4 threshold after last restart", "irq_status", irq_status, 1'b1);

    // R7: freeze
    start_run(2'd0, 1'b1, 1'b0, 10);
    run_enable = 1'b0;
    repeat (30) @(negedge clk);
    run_enable = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 frozen count", "irq_status", irq_status, 1'b0);
    @(negedge clk);
    check("R7 resumed count", "irq_status", irq_status, 1'b1);

    // R8: sticky, then clear
    repeat (3) @(negedge clk);
    check("R8 sticky", "irq_status", irq_status, 1'b1);
    run_enable = 1'b0;
    iclr = 1'b1; @(negedge clk); iclr = 1'b0;
    check("R8 cleared", "irq_status", irq_status, 1'b0);
    check("R3 request follows flag", "irq_req", irq_req, 1'b0);

    // R8: set wins over same-cycle clear
    start_run(2'd0, 1'b1, 1'b0, 15);
    iclr = 1'b1; @(negedge clk); iclr = 1'b0;
    check("R8 set beats clear", "irq_status", irq_status, 1'b1);

    // R6: wrap with reset disabled, interrupt comes round again
    start_run(2'd0, 1'b1, 1'b0, 24);
    iclr = 1'b1; @(negedge clk); iclr = 1'b0;
    repeat (14) @(negedge clk);
    check_all("R6 before second interrupt", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check_all("R6 second interrupt", 1'b1, 1'b0, 1'b1, 1'b0);

    // R1: mid-run reset
    start_run(2'd0, 1'b1, 1'b1, 25);
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 asynchronous clear", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule